// File: doc/BRIEF.md
# Fractional-Rate Data-Ready Generator

This block paces the output side of an oversampling converter. A fixed-rate modulator clock advances a phase accumulator by one whole unit on every accepted tick. Each time the accumulated phase reaches the programmed decimation ratio, the block emits a one-cycle data-ready strobe and steps a sample counter. The output data rate is therefore the tick rate divided by the ratio.

The ratio is unsigned fixed point and may have a fractional part, so the strobe spacing alternates between the two neighbouring whole tick counts and averages exactly to the ratio. Host logic can write a new ratio at any time. The new ratio waits in a staging register and becomes active at the next strobe. The accumulator is never cleared on a write, so the fractional residue carries across the change and no strobe is dropped, added or stretched. Controllers use this to nudge the sampling instant into line with a shared timing reference without breaking the data stream.

The data-ready strobe has no ready input and cannot be held back: it is an event marker, not a stream. Every other pin is plain control.

Top module: `frac_drdy_gen`

## Requirements
- R1: `ratio_in` is a 28-bit unsigned fixed-point value with the integer part in bits 27:16 and the fraction in bits 15:0. While reset is high and right after it, `drdy` is 0 and `sample_cnt` is 0. The active ratio comes out of reset at 32.0, so the first strobe follows the 32nd accepted tick.
- R2: An accepted tick is a cycle with `mod_tick` and `en` both high, and it adds 1.0 to the phase. Number the accepted ticks from 1 since reset. The j-th strobe marks tick ceil(S_j), where S_j is the sum of the ratios used for periods 1 through j. When the phase reaches the ratio, the ratio is subtracted and the remainder is kept.
- R3: `drdy` is high for exactly one cycle, namely the cycle after the accepted tick that completes a period. It is never high on two consecutive cycles.
- R4: A write (`ratio_load` high) of a value of at least 2.0 becomes active for the period that starts at the next strobe. If the write happens in the same cycle as the tick that completes a period, that period's successor still uses the previous staged value, and the write applies one period later. If several writes land before a strobe, the last one wins.
- R5: A write of a value below 2.0 (bits 27:17 all zero) is ignored. The staged and active ratios keep their values.
- R6: Changing the ratio never clears the phase, so the fractional residue of the old period is carried into the new one.
- R7: While `en` is low, ticks are not counted, the phase holds and no strobe is raised.
- R8: `sample_cnt` increments by one in the same cycle in which `drdy` is high, holds otherwise, and wraps modulo 2^CNT_W.
- R9: Synchronous active-high `rst` clears the phase and the counter and returns both the staged and the active ratio to 32.0, discarding any pending write.
- R10: Over any run of whole periods at a fixed ratio N, the number of ticks differs from periods × N by less than one tick, so the average period matches N within one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept modulator ticks when high |
| mod_tick | input | 1 | One-cycle modulator-rate enable |
| ratio_load | input | 1 | Write strobe for `ratio_in` |
| ratio_in | input | 28 | Decimation ratio, 12.16 unsigned fixed point |
| drdy | output | 1 | One-cycle data-ready strobe |
| sample_cnt | output | CNT_W | Running count of strobes |

## Verification
The bench derives each strobe's tick position from the running sum of ratios. It therefore catches a design that zeroes the phase on a ratio change, since the fractional residue would be lost and later strobes would drift by a tick. It also writes a ratio in the very cycle a period closes. A design that lets that write take effect at once would shorten or lengthen the following period. The bench sends sub-2.0 values that a careless design would accept, producing back-to-back strobes. It runs with `en` low under heavy ticking, wraps the sample counter, and issues a reset while a write is pending. A design that kept the pending value would pace the first post-reset period wrongly.

// File: rtl/frdy_pkg.sv
package frdy_pkg;
  // Default fixed-point layout of the decimation ratio.
  localparam int unsigned DEF_INT_W  = 12;
  localparam int unsigned DEF_FRAC_W = 16;
  // Default width of the running sample counter.
  localparam int unsigned DEF_CNT_W  = 16;
  // Default ratio after reset, whole part only.
  localparam int unsigned DEF_RESET_WHOLE = 32;
  // Smallest ratio accepted from a write.
  localparam int unsigned MIN_WHOLE = 2;
endpackage

// File: rtl/frdy_ratio_bank.sv
module frdy_ratio_bank #(
  parameter int unsigned INT_W = 12,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned MIN_WHOLE = 2,
  parameter logic [INT_W+FRAC_W-1:0] RESET_RATIO = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [INT_W+FRAC_W-1:0] load_val,
  input  logic                    boundary,
  output logic [INT_W+FRAC_W-1:0] active
);
  localparam int unsigned RATIO_W = INT_W + FRAC_W;
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_WHOLE) << FRAC_W;

  logic [RATIO_W-1:0] staged_q;
  logic [RATIO_W-1:0] active_q;
  logic               accept;

  // Writes below the floor would allow back-to-back strobes; drop them.
  assign accept = load && (load_val >= FLOOR);

  // The active ratio only moves at a period boundary, so no period
  // mixes two ratios. A write in the boundary cycle lands one period later.
  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= RESET_RATIO;
      active_q <= RESET_RATIO;
    end else begin
      if (boundary) active_q <= staged_q;
      if (accept)   staged_q <= load_val;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/frdy_phase_acc.sv
module frdy_phase_acc #(
  parameter int unsigned INT_W = 12,
  parameter int unsigned FRAC_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic [INT_W+FRAC_W-1:0]   ratio,
  output logic                      boundary,
  output logic [INT_W+FRAC_W:0]     phase
);
  // One guard bit so that phase + 1.0 never overflows below the max ratio.
  localparam int unsigned ACC_W = INT_W + FRAC_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] advanced;
  logic [ACC_W-1:0] ratio_ext;
  logic [ACC_W-1:0] phase_d;

  always_comb begin
    advanced  = phase_q + ONE;
    ratio_ext = {1'b0, ratio};
    boundary  = step && (advanced >= ratio_ext);
    if (!step)
      phase_d = phase_q;
    else if (boundary)
      phase_d = advanced - ratio_ext;  // residue carried into next period
    else
      phase_d = advanced;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/frdy_sample_ctr.sv
module frdy_sample_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  output logic             strobe,
  output logic [CNT_W-1:0] count
);
  logic             strobe_q;
  logic [CNT_W-1:0] count_q;

  // Strobe and count are registered together so they change in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      count_q  <= '0;
    end else begin
      strobe_q <= boundary;
      if (boundary) count_q <= count_q + CNT_W'(1);
    end
  end

  assign strobe = strobe_q;
  assign count  = count_q;
endmodule

// File: rtl/frac_drdy_gen.sv
module frac_drdy_gen
  import frdy_pkg::*;
#(
  parameter int unsigned INT_W = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned RESET_WHOLE = DEF_RESET_WHOLE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    mod_tick,
  input  logic                    ratio_load,
  input  logic [INT_W+FRAC_W-1:0] ratio_in,
  output logic                    drdy,
  output logic [CNT_W-1:0]        sample_cnt
);
  localparam int unsigned RATIO_W = INT_W + FRAC_W;
  localparam int unsigned ACC_W   = RATIO_W + 1;
  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(RESET_WHOLE) << FRAC_W;

  logic               step;
  logic               boundary;
  logic [RATIO_W-1:0] ratio_act;
  logic [ACC_W-1:0]   phase;

  assign step = en && mod_tick;

  frdy_ratio_bank #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_WHOLE(MIN_WHOLE), .RESET_RATIO(RESET_RATIO)
  ) bank_i (
    .clk(clk), .rst(rst), .load(ratio_load), .load_val(ratio_in),
    .boundary(boundary), .active(ratio_act)
  );

  frdy_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) acc_i (
    .clk(clk), .rst(rst), .step(step), .ratio(ratio_act),
    .boundary(boundary), .phase(phase)
  );

  frdy_sample_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .boundary(boundary),
    .strobe(drdy), .count(sample_cnt)
  );
endmodule

// File: rtl/frac_drdy_gen_chk.sv
module frac_drdy_gen_chk #(
  parameter int unsigned INT_W = 12,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MIN_WHOLE = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    mod_tick,
  input logic                    drdy,
  input logic [CNT_W-1:0]        sample_cnt,
  input logic [INT_W+FRAC_W-1:0] ratio_act,
  input logic [INT_W+FRAC_W:0]   phase
);
  localparam int unsigned RATIO_W = INT_W + FRAC_W;
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_WHOLE) << FRAC_W;

  // R3: a strobe only follows an accepted tick
  p_strobe_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    drdy |-> $past(mod_tick && en));

  // R3: never two strobes in a row
  p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    drdy |=> !drdy);

  // R7: disabled ticks never produce a strobe
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drdy);

  // R8: count steps with each strobe
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    drdy |-> sample_cnt == $past(sample_cnt) + CNT_W'(1));

  // R8: count holds between strobes
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !drdy |-> $stable(sample_cnt));

  // R5: the active ratio never falls under the floor
  p_ratio_floor_r5: assert property (@(posedge clk) disable iff (rst)
    ratio_act >= FLOOR);

  // R2: the stored phase stays below the active ratio
  p_phase_below_r2: assert property (@(posedge clk) disable iff (rst)
    phase < {1'b0, ratio_act});
endmodule

bind frac_drdy_gen frac_drdy_gen_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .MIN_WHOLE(MIN_WHOLE)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .mod_tick(mod_tick), .drdy(drdy),
  .sample_cnt(sample_cnt), .ratio_act(ratio_act), .phase(phase)
);

// File: tb/frac_drdy_gen_tb_top.sv
module frac_drdy_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int IW = 12;
  localparam int FW = 16;
  localparam int CW = 8;
  localparam int RW = IW + FW;
  localparam longint UNIT = 65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic mod_tick = 1'b0;
  logic ratio_load = 1'b0;
  logic [RW-1:0] ratio_in = '0;
  logic drdy;
  logic [CW-1:0] sample_cnt;

  always #(CLK_P/2) clk = ~clk;

  frac_drdy_gen #(.INT_W(IW), .FRAC_W(FW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mod_tick(mod_tick),
    .ratio_load(ratio_load), .ratio_in(ratio_in),
    .drdy(drdy), .sample_cnt(sample_cnt)
  );

  typedef struct { int tick; int samp; } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  int vecs = 0;
  int errs = 0;
  // driver-side expectation model (cumulative ratio sums)
  longint s_next, act_r, pend_r;
  int tcount, samp;
  // monitor state
  int mon_ticks = 0, mon_seen = 0, mon_last = 0;
  bit prev_drdy = 1'b0;

  function automatic longint fx(int whole, int frac16);
    return longint'(whole) * UNIT + longint'(frac16);
  endfunction

  task automatic chk(bit ok, string req, longint a, longint e);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, a, e);
    end
  endtask

  // One driven cycle; the model mirrors the requirements R2/R4/R5/R7.
  task automatic step(bit tk, bit e, bit ld, longint v);
    @(negedge clk);
    rst = 1'b0;
    mod_tick = tk;
    en = e;
    ratio_load = ld;
    ratio_in = RW'(v);
    if (tk && e) begin
      tcount++;
      if ((longint'(tcount) * UNIT) >= s_next) begin
        samp++;
        exp_q.push_back('{tick: tcount, samp: samp});
        act_r = pend_r;
        s_next += act_r;
      end
    end
    if (ld && v >= fx(2, 0)) pend_r = v;
  endtask

  task automatic run(int n, int every, bit e);
    for (int i = 0; i < n; i++) step((i % every) == 0, e, 1'b0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mod_tick = 1'b0; ratio_load = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    tcount = 0; samp = 0;
    act_r = fx(32, 0); pend_r = act_r; s_next = act_r;
  endtask

  // Monitor: pops expected strobes as the design produces them.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst) begin
        mon_ticks = 0;
        prev_drdy = 1'b0;
      end else begin
        if (mod_tick && en) mon_ticks++;
        if (drdy) begin
          mon_seen++;
          mon_last = mon_ticks;
          chk(!prev_drdy, "R3 one-cycle strobe", 1, 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected data-ready at tick", mon_ticks, -1);
          end else begin
            cur = exp_q.pop_front();
            chk(mon_ticks == cur.tick, "R2 data-ready tick", mon_ticks, cur.tick);
            chk(int'(sample_cnt) == (cur.samp % 256), "R8 sample count",
                sample_cnt, cur.samp % 256);
          end
        end
        prev_drdy = drdy;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int s0, l0;
    longint per, tks, diff;
    do_reset();
    #1;
    chk(drdy == 1'b0, "R1 drdy in reset", drdy, 0);
    chk(sample_cnt == '0, "R1 count in reset", sample_cnt, 0);

    // R1: default ratio 32.0, ticks every cycle
    run(100, 1, 1'b1);
    idle(3);
    chk(mon_seen == 3, "R1 strobes at reset ratio", mon_seen, 3);

    // R4 + R6: fractional ratio written mid-period, sparse ticks
    step(1'b1, 1'b1, 1'b1, fx(2, 32768));
    run(200, 3, 1'b1);

    // R4: last of several writes wins
    step(1'b0, 1'b1, 1'b1, fx(5, 0));
    step(1'b0, 1'b1, 1'b1, fx(7, 16384));
    run(60, 1, 1'b1);

    // R5: writes below 2.0 are ignored
    step(1'b0, 1'b1, 1'b1, fx(1, 65535));
    step(1'b0, 1'b1, 1'b1, 0);
    run(60, 1, 1'b1);

    // R4: write in the very cycle a period closes
    while ((longint'(tcount + 1) * UNIT) < s_next) step(1'b1, 1'b1, 1'b0, 0);
    step(1'b1, 1'b1, 1'b1, fx(3, 12345));
    run(80, 1, 1'b1);

    // R7: ticks with enable low are ignored
    run(50, 1, 1'b0);
    run(30, 2, 1'b1);

    // R10: average period over many periods
    step(1'b0, 1'b1, 1'b1, fx(37, 19661));
    run(90, 1, 1'b1);
    idle(3);
    s0 = mon_seen; l0 = mon_last;
    run(7460, 1, 1'b1);
    idle(3);
    per = longint'(mon_seen - s0);
    tks = longint'(mon_last - l0);
    diff = tks * UNIT - per * fx(37, 19661);
    if (diff < 0) diff = -diff;
    chk(per >= 150, "R10 periods observed", per, 150);
    chk(diff < UNIT, "R10 average period error (1/65536 tick)", diff, 0);

    // R8: counter wrap at ratio 2.0
    step(1'b0, 1'b1, 1'b1, fx(2, 0));
    run(700, 1, 1'b1);
    idle(3);
    chk(exp_q.size() == 0, "R8 all strobes before wrap check", exp_q.size(), 0);

    // R9: reset with a pending write discards it
    step(1'b0, 1'b1, 1'b1, fx(9, 0));
    idle(2);
    do_reset();
    #1;
    chk(drdy == 1'b0, "R9 drdy after reset", drdy, 0);
    chk(sample_cnt == '0, "R9 count after reset", sample_cnt, 0);
    run(40, 1, 1'b1);
    idle(3);
    chk(mon_seen > 0 && mon_last == 32, "R9 first period back at 32.0", mon_last, 32);

    idle(5);
    chk(exp_q.size() == 0, "R2 every expected data-ready seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule